// File: doc/BRIEF.md
# Transient Capture Cell

This cell watches one asynchronous digital line that should stay at a fixed idle level. When the line moves to the opposite level, the cell counts how many clock cycles the departure lasts. When the line returns, the cell presents that width to a controller. It then holds the record until the controller explicitly rearms it. Many cells can sit side by side. Each has its own idle-level setting, so a cell that catches dips from a high line can run next to one that catches spikes on a low line.

The raw line passes through a multi-flop synchroniser first, so every measurement is taken on the synchronised copy. The width counter stops at all ones instead of wrapping. The result leaves the cell on a valid/ready pair. Once valid rises, it stays high and the width stays stable until the controller accepts the record with ready high on a clock edge. Ready has no effect at any other time. After the handshake the cell ignores the line until the rearm input is pulsed. The rearm input takes precedence over everything in every state: it returns the cell to watching and clears the width. The state register may be built as three voted copies.

Top module: `transient_capture_cell`

## Requirements
- R1: After reset `event_valid_o` is 0 and `duration_o` is 0, and no event is reported while the line stays at its idle level.
- R2: With `nominal_i` = 1, a low excursion seen on P consecutive rising edges (P at least 1) is reported with `duration_o` = P. With `nominal_i` = 0, a high excursion seen on P edges is reported the same way.
- R3: `event_valid_o` rises in the third clock cycle after the line returns to its idle level: two synchroniser stages, then one state update.
- R4: While `event_valid_o` is 1 and `event_ready_i` is 0, `event_valid_o` stays 1 and `duration_o` stays unchanged. A clock edge with both high ends the offer, and `event_valid_o` is 0 from the next cycle.
- R5: After the handshake, further excursions on the line do not raise `event_valid_o` and do not change `duration_o` until rearm.
- R6: `rearm_i` high on a clock edge, in any state including mid-count, gives `event_valid_o` = 0 and `duration_o` = 0 from the next cycle. While it stays high, no event is captured.
- R7: The width counter saturates at 2^CNT_W-1 (65535 by default) and never wraps, however long the excursion lasts.
- R8: An excursion that is not present at any rising clock edge is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nominal_i | input | 1 | Idle level of the watched line (1: catch dips, 0: catch spikes) |
| line_i | input | 1 | Raw asynchronous line under watch |
| rearm_i | input | 1 | Synchronous rearm from the controller, highest priority |
| event_valid_o | output | 1 | A captured event is on offer |
| event_ready_i | input | 1 | Controller accepts the offered event |
| duration_o | output | CNT_W | Excursion width in clock cycles, saturating |

## Verification
The hardest state to reach is the saturated counter. It needs an excursion held for more than 65535 cycles, so the bench holds the line at the opposite level for 65540 cycles at the default width and checks the stopped value. Mid-count rearm also needs careful stimulus: the bench raises rearm while the line is still away from idle, then keeps rearm high until the synchroniser has flushed. A sub-cycle glitch is placed strictly between two rising edges to show it goes unseen.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_COUNT = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } cell_state_e;
  localparam int unsigned STATE_W = 2;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic primed_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      fill_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      fill_q <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  assign q_o      = pipe_q[STAGES-1];
  assign primed_o = fill_q[STAGES-1];
endmodule

// File: rtl/tcc_sat_counter.sv
module tcc_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] q_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (clr_i) begin
      q <= CNT_W'(inc_i);
    end else if (inc_i && (q != TOP)) begin
      q <= q + 1'b1;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/tcc_state_reg.sv
module tcc_state_reg #(
  parameter int unsigned W       = 2,
  parameter bit          USE_TMR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (USE_TMR) begin : g_tmr
    logic [W-1:0] r0, r1, r2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r0 <= '0;
        r1 <= '0;
        r2 <= '0;
      end else begin
        r0 <= d_i;
        r1 <= d_i;
        r2 <= d_i;
      end
    end
    assign q_o = (r0 & r1) | (r0 & r2) | (r1 & r2);
  end else begin : g_single
    logic [W-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r <= '0;
      else         r <= d_i;
    end
    assign q_o = r;
  end
endmodule

// File: rtl/transient_capture_cell.sv
module transient_capture_cell
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          USE_TMR     = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nominal_i,
  input  logic             line_i,
  input  logic             rearm_i,
  output logic             event_valid_o,
  input  logic             event_ready_i,
  output logic [CNT_W-1:0] duration_o
);
  logic             line_s, primed;
  logic             anomaly;
  logic [STATE_W-1:0] st_raw, nxt_raw;
  cell_state_e      st, nxt;
  logic             cnt_clr, cnt_inc;

  tcc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (line_i),
    .q_o      (line_s),
    .primed_o (primed)
  );

  assign anomaly = primed && (line_s != nominal_i);

  tcc_state_reg #(.W(STATE_W), .USE_TMR(USE_TMR)) i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt_raw),
    .q_o    (st_raw)
  );

  assign st      = cell_state_e'(st_raw);
  assign nxt_raw = nxt;

  always_comb begin
    nxt     = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (rearm_i) begin
      nxt     = ST_WATCH;
      cnt_clr = 1'b1;
    end else begin
      unique case (st)
        ST_WATCH: begin
          cnt_clr = 1'b1;
          if (anomaly) begin
            cnt_inc = 1'b1;
            nxt     = ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (anomaly) cnt_inc = 1'b1;
          else         nxt     = ST_SEND;
        end
        ST_SEND: begin
          if (event_ready_i) nxt = ST_WAIT;
        end
        ST_WAIT: nxt = ST_WAIT;
        default: nxt = ST_WATCH;
      endcase
    end
  end

  tcc_sat_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .q_o    (duration_o)
  );

  assign event_valid_o = (st == ST_SEND);
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rearm_i,
  input logic             event_valid_o,
  input logic             event_ready_i,
  input logic [CNT_W-1:0] duration_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R4
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_valid_o && !event_ready_i && !rearm_i) |=> (event_valid_o && $stable(duration_o)));

  // R4
  offer_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_valid_o && event_ready_i && !rearm_i) |=> !event_valid_o);

  // R6
  rearm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (!event_valid_o && duration_o == '0));

  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duration_o == TOP && !rearm_i) |=> (duration_o == TOP));

  // R5
  no_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rearm_i |=> (duration_o >= $past(duration_o)));
endmodule

bind transient_capture_cell tcc_checker #(.CNT_W(CNT_W)) i_tcc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rearm_i       (rearm_i),
  .event_valid_o (event_valid_o),
  .event_ready_i (event_ready_i),
  .duration_o    (duration_o)
);

// File: tb/test_transient_capture_cell.sv
`timescale 1ns/1ps
module test_transient_capture_cell;
  localparam int unsigned CNT_W = 16;
  localparam longint      TOP   = (64'd1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             nominal = 1'b1;
  logic             line = 1'b1;
  logic             rearm = 1'b0;
  logic             ready = 1'b0;
  logic             valid;
  logic [CNT_W-1:0] dur;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  transient_capture_cell #(.CNT_W(CNT_W)) i_transient_capture_cell (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .nominal_i     (nominal),
    .line_i        (line),
    .rearm_i       (rearm),
    .event_valid_o (valid),
    .event_ready_i (ready),
    .duration_o    (dur)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_rearm();
    rearm = 1'b1;
    cycles(1);
    rearm = 1'b0;
    chk(!valid && dur == 0, "R6", dur, 0);
  endtask

  // excursion seen on p edges; checks width and the offer timing
  task automatic pulse(input int p, input string req);
    @(negedge clk);
    line = ~nominal;
    repeat (p) @(posedge clk);
    @(negedge clk);
    line = nominal;
    cycles(2);
    chk(!valid, "R3", valid, 0);
    cycles(1);
    chk(valid, "R3", valid, 1);
    chk(dur == p, req, dur, p);
  endtask

  task automatic accept();
    ready = 1'b1;
    cycles(1);
    ready = 1'b0;
    chk(!valid, "R4", valid, 0);
  endtask

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    cycles(8);
    chk(!valid, "R1", valid, 0);
    chk(dur == 0, "R1", dur, 0);

    // R2 sweep, both idle levels
    for (int pol = 1; pol >= 0; pol--) begin
      rearm = 1'b1;
      nominal = pol[0];
      line = pol[0];
      cycles(4);
      rearm = 1'b0;
      cycles(2);
      for (int p = 1; p <= 40; p++) begin
        pulse(p, "R2");
        accept();
        do_rearm();
      end
    end

    // R4 hold under back-pressure, R5 ignore after handshake
    pulse(7, "R2");
    cycles(20);
    chk(valid, "R4", valid, 1);
    chk(dur == 7, "R4", dur, 7);
    accept();
    @(negedge clk) line = ~nominal;
    cycles(5);
    line = nominal;
    cycles(10);
    chk(!valid, "R5", valid, 0);
    chk(dur == 7, "R5", dur, 7);
    do_rearm();

    // R6 rearm mid-count, held while the line recovers
    @(negedge clk) line = ~nominal;
    cycles(10);
    rearm = 1'b1;
    cycles(1);
    chk(!valid && dur == 0, "R6", dur, 0);
    line = nominal;
    cycles(5);
    chk(!valid && dur == 0, "R6", dur, 0);
    rearm = 1'b0;
    cycles(10);
    chk(!valid, "R6", valid, 0);
    chk(dur == 0, "R6", dur, 0);

    // R8 glitch between edges
    for (int g = 0; g < 4; g++) begin
      @(posedge clk);
      #1 line = ~nominal;
      #1 line = nominal;
    end
    cycles(8);
    chk(!valid, "R8", valid, 0);
    chk(dur == 0, "R8", dur, 0);

    // R7 saturation
    @(negedge clk) line = ~nominal;
    cycles(int'(TOP) + 5);
    line = nominal;
    cycles(3);
    chk(valid, "R7", valid, 1);
    chk(dur == TOP, "R7", dur, TOP);
    accept();
    do_rearm();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule